// File: doc/BRIEF.md
# Environment Configuration CSR Bank

This block keeps the per-privilege environment configuration state of a hart: one register that machine mode owns, one that supervisor mode owns and one that hypervisor mode owns. The pipeline presents a 12-bit CSR address, an operation and a write operand. In the same cycle the block returns the read data and flags whether the access is illegal. A legal write, set or clear changes the target register at the next rising clock edge. Every implemented field of every register comes out on its own decoded port, for use by the cache-block, fence and page-attribute logic that lives elsewhere.

The machine and hypervisor registers are 64 bits wide. With `XLEN` set to 32, each has a second address that holds its upper word. A write to that address replaces the whole upper word and does not touch the lower one. A write to the low address replaces only the lower word. Bits that are not implemented are forced to zero on every update. The supervisor register carries only the four cache and fence fields.

Top module: `envcfg_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three registers become zero, and every field output reads zero after that edge.
- R2: Address 0x30A selects the machine register, 0x10A the supervisor register and 0x60A the hypervisor register. A legal access returns the selected register's low `XLEN` bits on `csr_rdata` in the same cycle.
- R3: Field positions are: bit 0 fence-I/O-as-memory enable, bits 5:4 cache-block invalidate enable, bit 6 clean/flush enable, bit 7 zero enable, bit 62 page memory type enable, bit 63 timer compare enable. The decoded outputs show a written value in the cycle after the write edge.
- R4: The machine and hypervisor registers keep only the bits in mask 0xC0000000_000000F1. The supervisor register keeps only the bits in mask 0xF1. All other bits read as zero.
- R5: With `XLEN` 32, address 0x31A (machine) and address 0x61A (hypervisor) reach bits 63:32. Bit 31 there is the timer compare enable and bit 30 the page memory type enable. A write to these addresses replaces bits 63:32 entirely and leaves bits 31:0 unchanged.
- R6: With `XLEN` 32, a write to a low address updates bits 31:0 and leaves bits 63:32 unchanged.
- R7: The `csr_op` encodings are: 00 read only (no change), 01 write (operand replaces), 10 set (current OR operand), 11 clear (current AND NOT operand). Each result is masked as in R4.
- R8: `priv` encodes 00 user, 01 supervisor, 11 machine, and 10 grants no access. Machine-register addresses need machine mode. The supervisor address needs supervisor or machine mode. Hypervisor addresses need `hyp_en` high and supervisor or machine mode.
- R9: An access to any other address is illegal. With `XLEN` 64, the high-half addresses are also illegal.
- R10: An illegal access raises `csr_illegal`, returns zero on `csr_rdata` and leaves all registers unchanged. `csr_illegal` is low whenever `csr_valid` is low, and a cycle without `csr_valid` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hyp_en | input | 1 | Hypervisor extension enabled |
| priv | input | 2 | Current privilege mode |
| csr_valid | input | 1 | Access request this cycle |
| csr_op | input | 2 | Operation: read, write, set, clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write operand |
| csr_rdata | output | XLEN | Read data (zero if illegal or idle) |
| csr_illegal | output | 1 | Illegal-access flag |
| m_fiom | output | 1 | Machine: fence I/O as memory |
| m_cbie | output | 2 | Machine: cache-block invalidate enable |
| m_cbcfe | output | 1 | Machine: clean/flush enable |
| m_cbze | output | 1 | Machine: zero enable |
| m_pbmte | output | 1 | Machine: page memory type enable |
| m_stce | output | 1 | Machine: timer compare enable |
| s_fiom | output | 1 | Supervisor: fence I/O as memory |
| s_cbie | output | 2 | Supervisor: invalidate enable |
| s_cbcfe | output | 1 | Supervisor: clean/flush enable |
| s_cbze | output | 1 | Supervisor: zero enable |
| h_fiom | output | 1 | Hypervisor: fence I/O as memory |
| h_cbie | output | 2 | Hypervisor: invalidate enable |
| h_cbcfe | output | 1 | Hypervisor: clean/flush enable |
| h_cbze | output | 1 | Hypervisor: zero enable |
| h_pbmte | output | 1 | Hypervisor: page memory type enable |
| h_stce | output | 1 | Hypervisor: timer compare enable |

## Verification
The bench sweeps every implemented address and several bad ones against all four privilege codes, both hypervisor-enable values, all four operations and a range of operand patterns. It keeps its own model of the three registers. A design that merged a high-half write into the old upper word instead of replacing it would keep stale timer or page-type bits, and the bench checks for this directly. A design with a missing reserved-bit mask would read back all-ones operands, set and clear built on an unmasked value would leak reserved bits, and a low write that clobbered the upper word would drop bits 62 and 63. The sweep also shows whether an illegal access changes state or returns nonzero data, and whether the reserved privilege code is wrongly granted access.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_SET   = 2'b10;
  localparam logic [1:0] OP_CLEAR = 2'b11;

  localparam logic [1:0] PRV_U = 2'b00;
  localparam logic [1:0] PRV_S = 2'b01;
  localparam logic [1:0] PRV_M = 2'b11;

  localparam logic [11:0] ADDR_MCFG   = 12'h30A;
  localparam logic [11:0] ADDR_MCFG_H = 12'h31A;
  localparam logic [11:0] ADDR_SCFG   = 12'h10A;
  localparam logic [11:0] ADDR_HCFG   = 12'h60A;
  localparam logic [11:0] ADDR_HCFG_H = 12'h61A;

  localparam int BIT_FIOM  = 0;
  localparam int BIT_CBIE  = 4;
  localparam int BIT_CBCFE = 6;
  localparam int BIT_CBZE  = 7;
  localparam int BIT_PBMTE = 62;
  localparam int BIT_STCE  = 63;

  localparam int NUM_REGS = 3;
  localparam int IDX_M = 0;
  localparam int IDX_S = 1;
  localparam int IDX_H = 2;

  typedef struct packed {
    logic       stce;
    logic       pbmte;
    logic       cbze;
    logic       cbcfe;
    logic [1:0] cbie;
    logic       fiom;
  } env_fields_t;

  // Writable bit mask; the top pair only for the wide registers.
  function automatic logic [63:0] impl_mask(input logic with_top);
    logic [63:0] m;
    m = '0;
    m[BIT_FIOM]     = 1'b1;
    m[BIT_CBIE +: 2] = 2'b11;
    m[BIT_CBCFE]    = 1'b1;
    m[BIT_CBZE]     = 1'b1;
    if (with_top) begin
      m[BIT_PBMTE] = 1'b1;
      m[BIT_STCE]  = 1'b1;
    end
    return m;
  endfunction

  function automatic env_fields_t split_fields(input logic [63:0] q);
    env_fields_t f;
    f.stce  = q[BIT_STCE];
    f.pbmte = q[BIT_PBMTE];
    f.cbze  = q[BIT_CBZE];
    f.cbcfe = q[BIT_CBCFE];
    f.cbie  = q[BIT_CBIE +: 2];
    f.fiom  = q[BIT_FIOM];
    return f;
  endfunction

endpackage

// File: rtl/envcfg_decode.sv
module envcfg_decode
  import envcfg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic        valid,
  input  logic [11:0] addr,
  input  logic [1:0]  priv,
  input  logic        hyp_en,
  output logic [NUM_REGS-1:0] sel_lo,
  output logic [NUM_REGS-1:0] sel_hi,
  output logic        illegal
);

  localparam bit SPLIT = (XLEN == 32);

  logic [NUM_REGS-1:0] hit_lo, hit_hi;
  logic at_m, at_s_or_m;
  logic ok_m, ok_s, ok_h, legal;

  always_comb begin
    hit_lo = '0;
    hit_hi = '0;
    unique case (addr)
      ADDR_MCFG:   hit_lo[IDX_M] = 1'b1;
      ADDR_MCFG_H: hit_hi[IDX_M] = SPLIT;
      ADDR_SCFG:   hit_lo[IDX_S] = HAS_SMODE;
      ADDR_HCFG:   hit_lo[IDX_H] = 1'b1;
      ADDR_HCFG_H: hit_hi[IDX_H] = SPLIT;
      default: ;
    endcase
  end

  assign at_m      = (priv == PRV_M);
  assign at_s_or_m = (priv == PRV_S) || at_m;

  assign ok_m  = (hit_lo[IDX_M] | hit_hi[IDX_M]) & at_m;
  assign ok_s  = hit_lo[IDX_S] & at_s_or_m;
  assign ok_h  = (hit_lo[IDX_H] | hit_hi[IDX_H]) & hyp_en & at_s_or_m;
  assign legal = ok_m | ok_s | ok_h;

  assign illegal = valid & ~legal;
  assign sel_lo  = (valid & legal) ? hit_lo : '0;
  assign sel_hi  = (valid & legal) ? hit_hi : '0;

endmodule

// File: rtl/envcfg_reg.sv
module envcfg_reg
  import envcfg_pkg::*;
#(
  parameter int          XLEN = 32,
  parameter logic [63:0] MASK = 64'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] wdata,
  output logic [63:0]     q
);

  function automatic logic [XLEN-1:0] apply_op(input logic [1:0] o,
                                               input logic [XLEN-1:0] cur,
                                               input logic [XLEN-1:0] opd);
    unique case (o)
      OP_WRITE: return opd;
      OP_SET:   return cur | opd;
      OP_CLEAR: return cur & ~opd;
      default:  return cur;
    endcase
  endfunction

  logic [XLEN-1:0] new_lo, new_hi;
  logic [63:0]     nxt;

  assign new_lo = apply_op(op, q[XLEN-1:0], wdata);
  assign new_hi = apply_op(op, XLEN'(q[63:32]), wdata);

  always_comb begin
    nxt = q;
    if (wr_lo)      nxt[XLEN-1:0] = new_lo;
    else if (wr_hi) nxt[63:32]    = new_hi[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt & MASK;
  end

endmodule

// File: rtl/envcfg_bank.sv
module envcfg_bank
  import envcfg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hyp_en,
  input  logic [1:0]      priv,
  input  logic            csr_valid,
  input  logic [1:0]      csr_op,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            m_fiom,
  output logic [1:0]      m_cbie,
  output logic            m_cbcfe,
  output logic            m_cbze,
  output logic            m_pbmte,
  output logic            m_stce,
  output logic            s_fiom,
  output logic [1:0]      s_cbie,
  output logic            s_cbcfe,
  output logic            s_cbze,
  output logic            h_fiom,
  output logic [1:0]      h_cbie,
  output logic            h_cbcfe,
  output logic            h_cbze,
  output logic            h_pbmte,
  output logic            h_stce
);

  localparam logic [63:0] WIDE_MASK   = impl_mask(1'b1);
  localparam logic [63:0] NARROW_MASK = impl_mask(1'b0);

  logic [NUM_REGS-1:0] sel_lo, sel_hi;
  logic [NUM_REGS-1:0] wr_lo, wr_hi;
  logic [63:0]         q [NUM_REGS];
  env_fields_t         fld [NUM_REGS];
  logic                wr_fire;
  logic [63:0]         q_m, q_s, q_h;

  envcfg_decode #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE)) u_dec (
    .valid   (csr_valid),
    .addr    (csr_addr),
    .priv    (priv),
    .hyp_en  (hyp_en),
    .sel_lo  (sel_lo),
    .sel_hi  (sel_hi),
    .illegal (csr_illegal)
  );

  assign wr_fire = (csr_op != OP_READ);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [63:0] M = (g == IDX_S) ? NARROW_MASK : WIDE_MASK;
    assign wr_lo[g] = sel_lo[g] & wr_fire;
    assign wr_hi[g] = sel_hi[g] & wr_fire;
    envcfg_reg #(.XLEN(XLEN), .MASK(M)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_lo[g]),
      .wr_hi (wr_hi[g]),
      .op    (csr_op),
      .wdata (csr_wdata),
      .q     (q[g])
    );
    assign fld[g] = split_fields(q[g]);
  end

  // Read path: one-hot select, zero when idle or illegal.
  always_comb begin
    csr_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel_lo[i]) csr_rdata = q[i][XLEN-1:0];
      if (sel_hi[i]) csr_rdata = XLEN'(q[i][63:32]);
    end
  end

  assign q_m = q[IDX_M];
  assign q_s = q[IDX_S];
  assign q_h = q[IDX_H];

  assign m_fiom  = fld[IDX_M].fiom;
  assign m_cbie  = fld[IDX_M].cbie;
  assign m_cbcfe = fld[IDX_M].cbcfe;
  assign m_cbze  = fld[IDX_M].cbze;
  assign m_pbmte = fld[IDX_M].pbmte;
  assign m_stce  = fld[IDX_M].stce;

  assign s_fiom  = fld[IDX_S].fiom;
  assign s_cbie  = fld[IDX_S].cbie;
  assign s_cbcfe = fld[IDX_S].cbcfe;
  assign s_cbze  = fld[IDX_S].cbze;

  assign h_fiom  = fld[IDX_H].fiom;
  assign h_cbie  = fld[IDX_H].cbie;
  assign h_cbcfe = fld[IDX_H].cbcfe;
  assign h_cbze  = fld[IDX_H].cbze;
  assign h_pbmte = fld[IDX_H].pbmte;
  assign h_stce  = fld[IDX_H].stce;

endmodule

// File: rtl/envcfg_bank_chk.sv
module envcfg_bank_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_valid,
  input logic [1:0]      csr_op,
  input logic [11:0]     csr_addr,
  input logic            csr_illegal,
  input logic [XLEN-1:0] csr_rdata,
  input logic            wr_fire,
  input logic [63:0]     q_m,
  input logic [63:0]     q_s,
  input logic [63:0]     q_h
);

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (q_m == 64'h0 && q_s == 64'h0 && q_h == 64'h0));

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_m & ~64'hC000_0000_0000_00F1) == 64'h0) &&
    ((q_h & ~64'hC000_0000_0000_00F1) == 64'h0) &&
    ((q_s & ~64'h0000_0000_0000_00F1) == 64'h0));

  p_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (XLEN == 32 && csr_valid && !csr_illegal && csr_addr == 12'h31A && wr_fire)
    |=> (q_m[31:0] == $past(q_m[31:0]) && $stable(q_s) && $stable(q_h)));

  p_read_op_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_op == 2'b00) |=> ($stable(q_m) && $stable(q_s) && $stable(q_h)));

  p_illegal_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  p_illegal_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> ($stable(q_m) && $stable(q_s) && $stable(q_h)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_valid |-> (!csr_illegal && csr_rdata == '0));

  p_idle_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_valid |=> ($stable(q_m) && $stable(q_s) && $stable(q_h)));

endmodule

bind envcfg_bank envcfg_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_valid   (csr_valid),
  .csr_op      (csr_op),
  .csr_addr    (csr_addr),
  .csr_illegal (csr_illegal),
  .csr_rdata   (csr_rdata),
  .wr_fire     (wr_fire),
  .q_m         (q_m),
  .q_s         (q_s),
  .q_h         (q_h)
);

// File: tb/tb_envcfg_bank.sv
module tb_envcfg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hyp_en = 1'b0;
  logic [1:0]      priv = 2'b11;
  logic            csr_valid = 1'b0;
  logic [1:0]      csr_op = 2'b00;
  logic [11:0]     csr_addr = 12'h0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_illegal;
  logic m_fiom, m_cbcfe, m_cbze, m_pbmte, m_stce;
  logic s_fiom, s_cbcfe, s_cbze;
  logic h_fiom, h_cbcfe, h_cbze, h_pbmte, h_stce;
  logic [1:0] m_cbie, s_cbie, h_cbie;

  int checks = 0;
  int fails  = 0;

  // Independent model of the three registers.
  logic [63:0] mod_m = '0, mod_s = '0, mod_h = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  envcfg_bank #(.XLEN(XLEN)) dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit may_access(input logic [11:0] a, input logic [1:0] p, input logic h);
    bit smode_up;
    smode_up = (p == 2'd1) || (p == 2'd3);
    case (a)
      12'h30A, 12'h31A: return p == 2'd3;
      12'h10A:          return smode_up;
      12'h60A, 12'h61A: return h && smode_up;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] combine(input logic [1:0] o, input logic [31:0] c, input logic [31:0] w);
    case (o)
      2'd1:    return w;
      2'd2:    return c | w;
      2'd3:    return c & ~w;
      default: return c;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h30A: return mod_m[31:0];
      12'h31A: return mod_m[63:32];
      12'h10A: return mod_s[31:0];
      12'h60A: return mod_h[31:0];
      12'h61A: return mod_h[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [1:0] o, input logic [31:0] w);
    case (a)
      12'h30A: mod_m[31:0]  = combine(o, mod_m[31:0], w);
      12'h31A: mod_m[63:32] = combine(o, mod_m[63:32], w);
      12'h10A: mod_s[31:0]  = combine(o, mod_s[31:0], w);
      12'h60A: mod_h[31:0]  = combine(o, mod_h[31:0], w);
      12'h61A: mod_h[63:32] = combine(o, mod_h[63:32], w);
      default: ;
    endcase
    mod_m = mod_m & 64'hC000_0000_0000_00F1;
    mod_h = mod_h & 64'hC000_0000_0000_00F1;
    mod_s = mod_s & 64'h0000_0000_0000_00F1;
  endtask

  task automatic check_fields(input string tag);
    check({tag, " m"}, 64'({m_stce, m_pbmte, m_cbze, m_cbcfe, m_cbie, m_fiom}),
          64'({mod_m[63], mod_m[62], mod_m[7], mod_m[6], mod_m[5:4], mod_m[0]}));
    check({tag, " s"}, 64'({s_cbze, s_cbcfe, s_cbie, s_fiom}),
          64'({mod_s[7], mod_s[6], mod_s[5:4], mod_s[0]}));
    check({tag, " h"}, 64'({h_stce, h_pbmte, h_cbze, h_cbcfe, h_cbie, h_fiom}),
          64'({mod_h[63], mod_h[62], mod_h[7], mod_h[6], mod_h[5:4], mod_h[0]}));
  endtask

  // One access: drive after a falling edge, check the combinational
  // response, then check the fields just after the rising edge.
  task automatic access(input logic [11:0] a, input logic [1:0] o, input logic [31:0] w,
                        input logic [1:0] p, input logic h);
    bit ok;
    @(negedge clk);
    csr_valid = 1'b1; csr_addr = a; csr_op = o; csr_wdata = w; priv = p; hyp_en = h;
    #1;
    ok = may_access(a, p, h);
    check("R8 R9 illegal flag", 64'(csr_illegal), 64'(!ok));
    check("R2 R5 R10 read data", 64'(csr_rdata), ok ? 64'(model_read(a)) : 64'h0);
    @(posedge clk);
    #1;
    if (ok && o != 2'd0) model_write(a, o, w);
    check_fields("R3 R4 R6 R7 fields");
    csr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [31:0] lfsr;
    logic [11:0] addrs [8];
    lfsr = 32'hACE1_2345;
    addrs = '{12'h30A, 12'h31A, 12'h10A, 12'h60A, 12'h61A, 12'h30B, 12'h20A, 12'h000};

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check_fields("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    csr_valid = 1'b0;
    #1;
    check("R10 idle illegal", 64'(csr_illegal), 64'h0);
    check("R10 idle rdata", 64'(csr_rdata), 64'h0);

    // R5: high-half write replaces, not merges
    access(12'h31A, 2'd1, 32'hFFFF_FFFF, 2'd3, 1'b0);
    access(12'h30A, 2'd1, 32'hFFFF_FFFF, 2'd3, 1'b0);
    access(12'h31A, 2'd1, 32'h4000_0000, 2'd3, 1'b0);
    access(12'h31A, 2'd0, 32'h0, 2'd3, 1'b0);
    check("R5 hi replace", {m_stce, m_pbmte}, 2'b01);
    // R6: low write keeps upper word
    access(12'h30A, 2'd1, 32'h0000_0001, 2'd3, 1'b0);
    check("R6 low keeps top", {m_stce, m_pbmte, m_cbze}, 3'b010);
    // R4: reserved bits of supervisor register
    access(12'h10A, 2'd1, 32'hFFFF_FFFF, 2'd1, 1'b0);
    access(12'h10A, 2'd0, 32'h0, 2'd1, 1'b0);
    // R8: reserved privilege code
    access(12'h10A, 2'd3, 32'hFFFF_FFFF, 2'd2, 1'b1);

    // Sweep: address x privilege x hyp enable x operation x operand
    for (int d = 0; d < 3; d++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pats[0] = 32'hFFFF_FFFF;
      pats[1] = lfsr;
      pats[2] = ~lfsr;
      pats[3] = 32'hC000_00F1 ^ lfsr;
      for (int ai = 0; ai < 8; ai++)
        for (int p = 0; p < 4; p++)
          for (int h = 0; h < 2; h++)
            for (int o = 0; o < 4; o++)
              access(addrs[ai], 2'(o), pats[(ai + p + o + d) % 4], 2'(p), 1'(h));
    end

    // R1: reset mid-run after state was built up
    access(12'h30A, 2'd2, 32'h0000_00F1, 2'd3, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    mod_m = '0; mod_s = '0; mod_h = '0;
    check_fields("R1 mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    access(12'h61A, 2'd0, 32'h0, 2'd1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule